// File: doc/BRIEF.md
# External Interrupt Edge Controller

This peripheral watches a set of external interrupt pins, synchronises each one into the local clock domain and detects a software-selected edge on it. A detected edge latches a request flag. The flags are masked by per-source enable bits, and the masked results are ORed into one interrupt line to the processor.

Software reaches the block through a simple synchronous register port. It has an address, write data, a write strobe, a read strobe and read data. Three byte-wide registers sit on this port. The polarity register chooses the edge for each pin. The mask register enables each source. The pending register holds the request flags. Software can clear a pending flag, but it can never set one.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the polarity register reads 0xE0, the mask register reads 0x00, the pending register reads 0x00 and irq_o is low.
- R2: Polarity bit i (i = 0 to 4) selects the edge detected on pin_i[i]: 0 selects a high-to-low transition and 1 selects a low-to-high transition. A transition in the other direction sets no flag.
- R3: Polarity register bits 7:5 always read 1 and ignore writes. Bits 4:0 read back the value last written.
- R4: A detected edge sets pending bit i whether or not mask bit i is set.
- R5: Writing the pending register clears every bit written as 0 and leaves every bit written as 1 unchanged. No write can set a pending bit.
- R6: If a detected edge and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R7: irq_o is high exactly when some source has both its pending bit and its mask bit set.
- R8: Changing a polarity bit while the pin is steady sets no flag. The edge detector uses the new polarity from the cycle after the write.
- R9: Bits 7:5 of the mask and pending registers read 0 and ignore writes.
- R10: The polarity register is at address 0xF2, the mask register at 0xF3 and the pending register at 0xF6. rdata_o shows the addressed register in the same cycle that rd_i is high. It is 0 when rd_i is low or the address is unmapped, and writes to unmapped addresses change nothing.
- R11: With the default two-stage synchroniser, a pin transition set up before a rising clock edge is visible in the pending register after the third rising edge, and is not yet visible after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (8) | Register address |
| wdata_i | input | DATA_W (8) | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W (8) | Read data, combinational |
| pin_i | input | NUM_SRC (5) | External interrupt pins, asynchronous |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: five sources, byte-wide data, 8-bit addresses and two synchroniser stages. Together these fix the latency from a pin transition to its flag at exactly three clock edges. That makes it possible to time a clearing write so that it lands on the same edge as a hardware set, and to sample the pending register one edge before and one edge after the flag is due. Five sources in an 8-bit register leave three unused bits in every register, so the fixed-one and fixed-zero read-back bits are exercised as well.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned DEF_ADDR_W  = 8;
  localparam int unsigned DEF_DATA_W  = 8;
  localparam int unsigned DEF_NUM_SRC = 5;
  localparam logic [7:0] OFS_POL  = 8'hF2;
  localparam logic [7:0] OFS_MASK = 8'hF3;
  localparam logic [7:0] OFS_PEND = 8'hF6;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned N      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] sync_o
);
  logic [STAGES-1:0][N-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/ext_irq_edge.sv
module ext_irq_edge #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] edge_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;

  // an edge needs a real level change; polarity only picks its direction
  assign edge_o = (sync_i ^ prev_q) & ~(sync_i ^ pol_i);

  // R8
  edge_needs_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o != '0) |-> ((edge_o & (sync_i ^ $past(sync_i))) == edge_o));

  // R2
  edge_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o != '0) |-> ((edge_o & sync_i) == (edge_o & pol_i)));
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] edge_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_data_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] clr;

  assign clr = clr_we_i ? ~clr_data_i : '0;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr) | edge_i;

  assign flag_o = flag_q;

  // R5
  no_sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q & ~$past(flag_q) & ~$past(edge_i)) == '0);

  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i != '0) |=> ((flag_q & $past(edge_i)) == $past(edge_i)));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC     = DEF_NUM_SRC,
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ADDR_POL  = ADDR_W'(OFS_POL),
  parameter logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(OFS_MASK),
  parameter logic [ADDR_W-1:0] ADDR_PEND = ADDR_W'(OFS_PEND)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_SRC-1:0] pin_i,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] pol_q, mask_q, sync, edges, flags;
  logic sel_pol, sel_mask, sel_pend;
  logic unused_wdata;

  assign sel_pol  = (addr_i == ADDR_POL);
  assign sel_mask = (addr_i == ADDR_MASK);
  assign sel_pend = (addr_i == ADDR_PEND);
  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_SRC];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pol_q  <= '0;
      mask_q <= '0;
    end else if (wr_i) begin
      if (sel_pol)  pol_q  <= wdata_i[NUM_SRC-1:0];
      if (sel_mask) mask_q <= wdata_i[NUM_SRC-1:0];
    end

  ext_irq_sync #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .sync_o(sync)
  );

  ext_irq_edge #(.N(NUM_SRC)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync),
    .pol_i (pol_q),
    .edge_o(edges)
  );

  ext_irq_flags #(.N(NUM_SRC)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (edges),
    .clr_we_i  (wr_i && sel_pend),
    .clr_data_i(wdata_i[NUM_SRC-1:0]),
    .flag_o    (flags)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (sel_pol)       rdata_o = {{PAD_W{1'b1}}, pol_q};
      else if (sel_mask) rdata_o = {{PAD_W{1'b0}}, mask_q};
      else if (sel_pend) rdata_o = {{PAD_W{1'b0}}, flags};
    end
  end

  assign irq_o = |(flags & mask_q);

  // R3
  pol_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_pol) |-> (rdata_o[DATA_W-1:NUM_SRC] == {PAD_W{1'b1}}));

  // R9
  mask_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (sel_mask || sel_pend)) |-> (rdata_o[DATA_W-1:NUM_SRC] == '0));

  // R7
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);

  // R10
  idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));
endmodule

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] rdata;
  logic [4:0] pins = 5'h1F;
  logic       irq;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .pin_i(pins), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [7:0] e);
    logic [7:0] d;
    bus_rd(a, d);
    check(req, d, e);
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk);
    pins[i] = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 irq", irq, 0);
    expect_reg("R1 pol", 8'hF2, 8'hE0);
    expect_reg("R1 mask", 8'hF3, 8'h00);
    expect_reg("R1 pend", 8'hF6, 8'h00);
  endtask

  task automatic t_latency();
    set_pin(0, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd = 1'b1; addr = 8'hF6;
    #1 check("R11 early", rdata, 8'h00);
    rd = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b1;
    #1 check("R11 due", rdata, 8'h01);
    rd = 1'b0;
    check("R4 flag w/o enable, irq low", irq, 0);
  endtask

  task automatic t_clear();
    set_pin(1, 1'b0);
    settle();
    expect_reg("R4 second flag", 8'hF6, 8'h03);
    bus_wr(8'hF6, 8'hFE);
    expect_reg("R5 clear bit0 only", 8'hF6, 8'h02);
    bus_wr(8'hF6, 8'hFF);
    expect_reg("R5 ones keep", 8'hF6, 8'h02);
    bus_wr(8'hF6, 8'h00);
    expect_reg("R5 clear all", 8'hF6, 8'h00);
    bus_wr(8'hF6, 8'hFF);
    expect_reg("R5 no sw set", 8'hF6, 8'h00);
  endtask

  task automatic t_rising();
    bus_wr(8'hF2, 8'hFF);
    expect_reg("R3 all ones", 8'hF2, 8'hFF);
    bus_wr(8'hF2, 8'h04);
    expect_reg("R3 upper fixed", 8'hF2, 8'hE4);
    set_pin(2, 1'b0);
    settle();
    expect_reg("R2 fall ignored when rising", 8'hF6, 8'h00);
    set_pin(2, 1'b1);
    settle();
    expect_reg("R2 rise detected", 8'hF6, 8'h04);
    bus_wr(8'hF6, 8'h00);
  endtask

  task automatic t_polarity();
    bus_wr(8'hF2, 8'h0C);
    settle();
    expect_reg("R8 no false edge to rising", 8'hF6, 8'h00);
    bus_wr(8'hF2, 8'h04);
    settle();
    expect_reg("R8 no false edge to falling", 8'hF6, 8'h00);
    set_pin(3, 1'b0);
    settle();
    expect_reg("R8 new polarity used", 8'hF6, 8'h08);
    bus_wr(8'hF6, 8'h00);
  endtask

  task automatic t_enable();
    bus_wr(8'hF3, 8'hFF);
    expect_reg("R9 mask upper zero", 8'hF3, 8'h1F);
    @(negedge clk);
    check("R7 no flags no irq", irq, 0);
    set_pin(4, 1'b0);
    settle();
    expect_reg("R4 pin4 flag", 8'hF6, 8'h10);
    check("R7 irq asserted", irq, 1);
    bus_wr(8'hF3, 8'h01);
    @(negedge clk);
    check("R7 masked off", irq, 0);
    bus_wr(8'hF3, 8'h10);
    @(negedge clk);
    check("R7 re-enabled", irq, 1);
    bus_wr(8'hF6, 8'hE0);
    expect_reg("R9 pend upper ignored", 8'hF6, 8'h00);
    check("R7 cleared", irq, 0);
  endtask

  task automatic t_race();
    set_pin(0, 1'b1);
    settle();
    expect_reg("R2 rise ignored when falling", 8'hF6, 8'h00);
    set_pin(0, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    addr = 8'hF6; wdata = 8'h00; wr = 1'b1;
    @(posedge clk);
    #1 wr = 1'b0;
    expect_reg("R6 set wins", 8'hF6, 8'h01);
    bus_wr(8'hF6, 8'h00);
  endtask

  task automatic t_decode();
    expect_reg("R10 unmapped 0x00", 8'h00, 8'h00);
    expect_reg("R10 unmapped 0xF4", 8'hF4, 8'h00);
    @(negedge clk);
    addr = 8'hF2; rd = 1'b0;
    #1 check("R10 idle read zero", rdata, 0);
    bus_wr(8'hF4, 8'hFF);
    expect_reg("R10 stray write mask", 8'hF3, 8'h10);
    expect_reg("R10 stray write pol", 8'hF2, 8'hE4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_latency();
    t_clear();
    t_rising();
    t_polarity();
    t_enable();
    t_race();
    t_decode();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule